// File: doc/BRIEF.md
# Converter Self-Calibration Trigger Sequencer

This block decides when a converter core runs its self-calibration and tracks the cycle while it is in progress. Two request sources are accepted: an external request pin and a request bit written by software. Each is passed through its own synchroniser on the input clock, and the two results are ORed into one request. A calibration is accepted only after a deliberate pattern: the request must sit low for a minimum number of cycles and then sit high for a minimum number of cycles. A shorter phase in either direction is treated as noise, and qualification starts over.

Once a cycle is accepted, the block raises a busy flag for the whole cycle. It steps through an optional termination-resistor trim phase and then a fixed number of converter-core steps. Each phase lasts a parameterised number of clock cycles, so the block stands in for the timing of the analog calibration. The trim phase is skipped only when extended control mode is active and the trim-disable bit is set. This choice also sets clock gating: while a cycle that includes trim is running, the data-clock enable is held low. When trim is skipped, the data clock keeps running through the cycle.

Top module: `cal_seq_top`

## Requirements
- R1: After reset, cal_busy is 0, dclk_en is 1, cal_phase is 2'b00 (idle) and cal_step is 0.
- R2: The combined request is the OR of the synchronised pin and the synchronised register bit, each delayed by SYNC_STAGES clock edges. It must be low for at least T_LOW consecutive cycles and then high for T_HIGH consecutive cycles. cal_busy rises on the clock edge that ends the T_HIGH-th high cycle. Exactly T_LOW low cycles followed by exactly T_HIGH high cycles is enough.
- R3: A low phase shorter than T_LOW, followed by any length of high, starts no cycle.
- R4: A high phase shorter than T_HIGH clears the qualification. A following low phase must again last at least T_LOW cycles before a high phase can start a cycle.
- R5: The register bit alone starts a cycle exactly as the pin does. High periods of the two sources that overlap or follow each other count as one high phase of the combined request.
- R6: Request activity while cal_busy is 1 is ignored. A request still held high when busy falls starts nothing; a fresh low phase of T_LOW cycles is needed.
- R7: When trim is included, cal_busy stays high for TRIM_CYCLES + N_STEPS*STEP_CYCLES cycles. cal_phase is 2'b01 for the first TRIM_CYCLES cycles, with cal_step at 0. It is then 2'b10, with cal_step counting 0 to N_STEPS-1, each value lasting STEP_CYCLES cycles.
- R8: Trim is skipped only when ext_ctrl_mode and trim_disable are both 1 at the start edge. The cycle then lasts N_STEPS*STEP_CYCLES cycles, entirely in phase 2'b10. With ext_ctrl_mode at 0, trim_disable has no effect.
- R9: dclk_en is 0 during every busy cycle of a calibration that includes trim. It is 1 during a calibration that skips trim, and 1 whenever cal_busy is 0.
- R10: The trim choice is captured at the start edge. Changing ext_ctrl_mode or trim_disable while busy alters neither the phases nor the length of the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_pin | input | 1 | External calibration request, asynchronous |
| cal_reg_bit | input | 1 | Software calibration request bit, asynchronous |
| ext_ctrl_mode | input | 1 | Extended control mode enable |
| trim_disable | input | 1 | Resistor trim disable, honoured in extended control mode only |
| cal_busy | output | 1 | High for the whole calibration cycle |
| dclk_en | output | 1 | Data-clock output enable |
| cal_phase | output | 2 | 00 idle, 01 termination trim, 10 core steps |
| cal_step | output | STEP_W | Index of the current core step |

## Verification
The bench builds the block with T_LOW=4, T_HIGH=3, N_STEPS=3, STEP_CYCLES=5, TRIM_CYCLES=7 and the default two synchroniser stages. With these values a whole calibration takes 22 or 15 cycles. Patterns at exactly T_LOW and T_HIGH, and at one cycle short of each, fit within a few cycles. Requests issued during a cycle, config changes mid-cycle and a request held high across the end of a cycle can all be exercised many times in a short run.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_TRIM = 2'b01,
    PH_CORE = 2'b10
  } cal_phase_e;

endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b0;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/cal_trig_qual.sv
module cal_trig_qual #(
  parameter int T_LOW  = 8,
  parameter int T_HIGH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic busy,
  output logic go
);

  localparam int LW = $clog2(T_LOW + 1);
  localparam int HW = $clog2(T_HIGH + 1);

  logic [LW-1:0] low_cnt;
  logic [LW-1:0] low_next;
  logic [HW-1:0] high_cnt;
  logic          armed;

  always_comb begin
    low_next = (low_cnt == LW'(T_LOW)) ? low_cnt : low_cnt + 1'b1;
    go       = !busy && req && armed && (high_cnt == HW'(T_HIGH - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      armed    <= 1'b0;
    end else if (busy || go) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      armed    <= 1'b0;
    end else if (!req) begin
      low_cnt  <= low_next;
      high_cnt <= '0;
      armed    <= (low_next == LW'(T_LOW));
    end else begin
      low_cnt  <= '0;
      high_cnt <= armed ? high_cnt + 1'b1 : '0;
    end
  end

  AST_HIGH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (high_cnt != '0) |-> armed); // R4

  AST_ARM_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> !$past(req)); // R3

  AST_QUAL_CLEARED_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!armed && high_cnt == '0)); // R6

endmodule

// File: rtl/cal_step_engine.sv
module cal_step_engine
  import cal_seq_pkg::*;
#(
  parameter int N_STEPS     = 4,
  parameter int STEP_CYCLES = 32,
  parameter int TRIM_CYCLES = 64,
  parameter int STEP_W      = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              trim_req,
  output logic              busy,
  output logic              trim_incl,
  output cal_phase_e        phase,
  output logic [STEP_W-1:0] step_idx
);

  localparam int MAXC = (STEP_CYCLES > TRIM_CYCLES) ? STEP_CYCLES : TRIM_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  cal_phase_e    state;
  logic [CW-1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_IDLE;
      cyc       <= '0;
      step_idx  <= '0;
      trim_incl <= 1'b0;
    end else begin
      case (state)
        PH_IDLE: begin
          if (go) begin
            trim_incl <= trim_req;
            state     <= trim_req ? PH_TRIM : PH_CORE;
            cyc       <= '0;
            step_idx  <= '0;
          end
        end
        PH_TRIM: begin
          if (cyc == CW'(TRIM_CYCLES - 1)) begin
            state <= PH_CORE;
            cyc   <= '0;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        PH_CORE: begin
          if (cyc == CW'(STEP_CYCLES - 1)) begin
            cyc <= '0;
            if (step_idx == STEP_W'(N_STEPS - 1)) begin
              state    <= PH_IDLE;
              step_idx <= '0;
            end else begin
              step_idx <= step_idx + 1'b1;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign busy  = (state != PH_IDLE);
  assign phase = state;

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx <= STEP_W'(N_STEPS - 1)); // R7

  AST_TRIM_LEADS_TO_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_TRIM) |=> (state != PH_IDLE)); // R7

  AST_SKIP_HAS_NO_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !trim_incl) |-> (state != PH_TRIM)); // R8

  AST_CHOICE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(trim_incl)); // R10

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int T_LOW       = 8,
  parameter int T_HIGH      = 8,
  parameter int N_STEPS     = 4,
  parameter int STEP_CYCLES = 32,
  parameter int TRIM_CYCLES = 64,
  parameter int STEP_W      = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_pin,
  input  logic              cal_reg_bit,
  input  logic              ext_ctrl_mode,
  input  logic              trim_disable,
  output logic              cal_busy,
  output logic              dclk_en,
  output logic [1:0]        cal_phase,
  output logic [STEP_W-1:0] cal_step
);

  localparam int NSRC = 2;

  logic [NSRC-1:0] src_raw;
  logic [NSRC-1:0] src_sync;
  logic            req;
  logic            go;
  logic            trim_req;
  logic            trim_incl;
  cal_phase_e      phase;

  assign src_raw = {cal_reg_bit, cal_pin};

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_sync
      cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_raw[g]),
        .q     (src_sync[g])
      );
    end
  endgenerate

  assign req      = |src_sync;
  assign trim_req = !(ext_ctrl_mode && trim_disable);

  cal_trig_qual #(.T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .busy  (cal_busy),
    .go    (go)
  );

  cal_step_engine #(
    .N_STEPS     (N_STEPS),
    .STEP_CYCLES (STEP_CYCLES),
    .TRIM_CYCLES (TRIM_CYCLES),
    .STEP_W      (STEP_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .trim_req  (trim_req),
    .busy      (cal_busy),
    .trim_incl (trim_incl),
    .phase     (phase),
    .step_idx  (cal_step)
  );

  assign cal_phase = phase;
  assign dclk_en   = !(cal_busy && trim_incl);

  AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> cal_busy); // R2

  AST_GATE_DURING_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TRIM) |-> !dclk_en); // R9

  AST_NO_GO_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cal_busy) && cal_busy |-> !go); // R6

endmodule

// File: tb/cal_seq_top_test.sv
`timescale 1ns/1ps
module cal_seq_top_test;

  localparam int TL = 4, TH = 3, NS = 3, SC = 5, TC = 7;
  localparam int LEN_TRIM = TC + NS * SC;
  localparam int LEN_SKIP = NS * SC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cal_pin = 1'b0, cal_reg_bit = 1'b0, ext_ctrl_mode = 1'b0, trim_disable = 1'b0;
  logic cal_busy, dclk_en;
  logic [1:0] cal_phase;
  logic [1:0] cal_step;

  cal_seq_top #(.SYNC_STAGES(2), .T_LOW(TL), .T_HIGH(TH), .N_STEPS(NS),
                .STEP_CYCLES(SC), .TRIM_CYCLES(TC)) uut (
    .clk(clk), .rst_n(rst_n), .cal_pin(cal_pin), .cal_reg_bit(cal_reg_bit),
    .ext_ctrl_mode(ext_ctrl_mode), .trim_disable(trim_disable),
    .cal_busy(cal_busy), .dclk_en(dclk_en), .cal_phase(cal_phase), .cal_step(cal_step));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";

  // behavioural reference: delay lines, counts, elapsed time in cycle
  int p_d[2], r_d[2];
  int m_low, m_high, m_armed, m_busy, m_el, m_total, m_trim;

  always @(posedge clk) begin
    int req, g, ob;
    if (!rst_n) begin
      p_d = '{0, 0}; r_d = '{0, 0};
      m_low = 0; m_high = 0; m_armed = 0; m_busy = 0; m_el = 0; m_total = 0; m_trim = 0;
    end else begin
      req = p_d[1] | r_d[1];
      g = (!m_busy && req && m_armed && m_high == TH - 1) ? 1 : 0;
      ob = m_busy;
      if (m_busy) begin
        m_el++;
        if (m_el == m_total) m_busy = 0;
      end else if (g) begin
        m_busy = 1; m_el = 0;
        m_trim = (ext_ctrl_mode && trim_disable) ? 0 : 1;
        m_total = (m_trim ? TC : 0) + NS * SC;
      end
      if (ob || g) begin
        m_low = 0; m_high = 0; m_armed = 0;
      end else if (!req) begin
        if (m_low < TL) m_low++;
        m_high = 0;
        m_armed = (m_low >= TL) ? 1 : 0;
      end else begin
        m_low = 0;
        m_high = m_armed ? m_high + 1 : 0;
      end
      p_d[1] = p_d[0]; p_d[0] = cal_pin;
      r_d[1] = r_d[0]; r_d[0] = cal_reg_bit;
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int e_ph, e_st, e_dc;
    if (!m_busy) begin e_ph = 0; e_st = 0; end
    else if (m_trim && m_el < TC) begin e_ph = 1; e_st = 0; end
    else begin e_ph = 2; e_st = (m_el - (m_trim ? TC : 0)) / SC; end
    e_dc = (m_busy && m_trim) ? 0 : 1;
    check(cur_tag, int'(cal_busy), m_busy, "busy");
    check(cur_tag, int'(dclk_en), e_dc, "dclk_en");
    check(cur_tag, int'(cal_phase), e_ph, "phase");
    check(cur_tag, int'(cal_step), e_st, "step");
  end

  // independent observation of starts and cycle length
  int rises = 0, run_len = 0, last_len = 0, prev_busy = 0;
  always @(negedge clk) begin
    if (cal_busy && !prev_busy) rises++;
    if (cal_busy) run_len++;
    if (!cal_busy && prev_busy) begin last_len = run_len; run_len = 0; end
    prev_busy = int'(cal_busy);
  end

  task automatic drive(logic p, logic r, int n);
    cal_pin = p; cal_reg_bit = r;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (cal_busy && guard < 200) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check("R1", int'(cal_busy), 0, "reset busy");
    check("R1", int'(dclk_en), 1, "reset dclk_en");
    check("R1", int'(cal_phase), 0, "reset phase");
    check("R1", int'(cal_step), 0, "reset step");
    rst_n = 1'b1;

    // R2 exact minimum pattern from the pin, R7 trim included, R6 held high after end
    cur_tag = "R2";
    drive(1, 0, 6); r0 = rises;
    drive(0, 0, TL); drive(1, 0, TH);
    cur_tag = "R7";
    drive(1, 0, 40);
    check("R2", rises - r0, 1, "starts after exact pattern");
    check("R7", last_len, LEN_TRIM, "trim cycle length");
    check("R6", int'(cal_busy), 0, "no restart while held high");

    // R3 low phase one short
    cur_tag = "R3"; r0 = rises;
    drive(0, 0, TL - 1); drive(1, 0, 10);
    check("R3", rises - r0, 0, "short low rejected");

    // R4 broken high phase then short low
    cur_tag = "R4"; r0 = rises;
    drive(0, 0, TL); drive(1, 0, TH - 1); drive(0, 0, TL - 1); drive(1, 0, 10);
    check("R4", rises - r0, 0, "short high clears arming");

    // R5 register bit alone, R8 trim skipped in extended mode, R9 clock keeps running
    cur_tag = "R5"; r0 = rises;
    ext_ctrl_mode = 1'b1; trim_disable = 1'b1;
    drive(0, 1, 5); drive(0, 0, TL); drive(0, 1, TH);
    cur_tag = "R8";
    drive(0, 1, 30);
    check("R5", rises - r0, 1, "register bit starts cycle");
    check("R8", last_len, LEN_SKIP, "skip cycle length");

    // R5 overlapping sources, R6 activity during busy, R10 config change mid-cycle
    cur_tag = "R5"; r0 = rises;
    trim_disable = 1'b0;
    drive(0, 0, TL + 1);
    drive(1, 0, 1); drive(1, 1, 1); drive(0, 1, 1);
    cur_tag = "R10";
    drive(0, 0, 3);
    trim_disable = 1'b1;
    drive(0, 0, TL + 1); drive(1, 0, TH + 1); drive(0, 0, 2);
    drive(1, 1, 1);
    wait_idle();
    drive(1, 0, 10);
    check("R5", rises - r0, 1, "combined sources start one cycle");
    check("R10", last_len, LEN_TRIM, "length fixed at start");
    check("R6", int'(cal_busy), 0, "busy-time pattern ignored");

    // R8 trim_disable outside extended mode has no effect
    cur_tag = "R8"; r0 = rises;
    ext_ctrl_mode = 1'b0; trim_disable = 1'b1;
    drive(0, 0, TL); drive(1, 0, TH);
    cur_tag = "R9";
    drive(1, 0, 3);
    check("R9", int'(dclk_en), 0, "clock gated with trim");
    drive(1, 0, 30);
    check("R8", rises - r0, 1, "start outside extended mode");
    check("R8", last_len, LEN_TRIM, "trim kept outside extended mode");

    report();
  end

endmodule